// File: doc/BRIEF.md
# Merging Request Buffer with Per-Slot Reference Counts

This block is a small, fully associative buffer of `K` slots that sits in front of a single memory bank. It merges requests that target the same address, so that requests already in flight share one bank access and one stored data word. Each request is looked up against the held addresses in the same cycle it is presented. On a hit, the block returns the slot that already holds the address. On a miss with a free slot, it claims the lowest-numbered free slot and asks for a bank access. On a miss with every slot taken, it raises a stall.

The bank later returns fill data, tagged with the slot number. The requester delivers departing requests by naming a slot, and it receives that slot's data word in the same cycle. Each slot keeps a count of requests that are still pending. The count rises by one for every accepted request to the slot and falls by one for every delivery from it. The slot is released when the count returns to zero.

Each slot runs a three-state machine:

- `ST_FREE`: the slot is empty.
- `ST_WAIT`: the slot is claimed and waiting for its data.
- `ST_READY`: the slot holds data.

The transitions are:

- **alloc**: `ST_FREE` to `ST_WAIT`, on an accepted miss.
- **fill**: `ST_WAIT` to `ST_READY`, on bank data.
- **release**: `ST_WAIT` or `ST_READY` to `ST_FREE`, when the last pending delivery leaves.
- **hold**: every other case.

Top module: `mrb_merge_buf`

## Requirements
- R1: After reset every slot is free. With `req_valid` low, `req_hit`, `req_stall` and `bank_req` are all 0.
- R2: A request whose address matches no held slot, while a slot is free, gives `req_hit`=0, `bank_req`=1 and `req_slot` = the lowest-numbered free slot, all in the same cycle as the request.
- R3: A request whose address matches a held slot gives `req_hit`=1, `req_slot` = that slot and `bank_req`=0, in the same cycle.
- R4: A slot stays held, so that requests to its address keep hitting, until the number of deliveries from it equals the number of requests accepted for it. It is released in the cycle after that last delivery.
- R5: A released slot can be claimed again, and the lowest-numbered free slot is always chosen first.
- R6: A miss while all `K` slots are held gives `req_stall`=1 and `bank_req`=0. A stalled request changes no slot: no slot is claimed and no count changes.
- R7: An accepted hit and a delivery on the same slot in the same cycle leave that slot's count unchanged.
- R8: `fill_valid` with `fill_slot` writes `fill_data` into a waiting slot. `dep_valid` with `dep_slot` returns that slot's data on `dep_data` in the same cycle. Delivering from a slot that has not been filled is a usage error and is flagged by an assertion.
- R9: A hit on a slot whose count is already at its maximum (2^`CNT_W`-1) gives `req_stall`=1 with `req_hit`=1, and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented |
| req_addr | input | AW | Address of the request |
| req_hit | output | 1 | The address is already held |
| req_slot | output | IW | Slot that was hit, or slot to be claimed |
| req_stall | output | 1 | The request cannot be taken this cycle |
| bank_req | output | 1 | A new bank access is needed for `req_slot` |
| fill_valid | input | 1 | The bank returns data |
| fill_slot | input | IW | Slot the fill data belongs to |
| fill_data | input | DW | Fill data word |
| dep_valid | input | 1 | One pending request departs |
| dep_slot | input | IW | Slot the departing request uses |
| dep_data | output | DW | Data word of `dep_slot` |

## Verification
A reference count that is wrong in either direction shows up at the ports, at the latest at the next request to that address once the expected number of deliveries has been made.

- **Count too low**: the slot is freed early, so a later request to the same address misses and raises `bank_req` when it should have hit.
- **Count too high**: the slot never frees, so a later request to that address still hits when it should miss. A later miss can also stall where a free slot was expected.
- **Wrong state machine or encoder**: this appears in the same cycle as the request, as a wrong `req_slot`. A missing or stale fill appears as a wrong `dep_data` on the very next delivery.

// File: rtl/mrb_pkg.sv
package mrb_pkg;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2
    } slot_state_e;

endpackage

// File: rtl/mrb_slot.sv
module mrb_slot
    import mrb_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int CNT_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_i,
    input  logic          inc_i,
    input  logic          dec_i,
    input  logic          fill_i,
    input  logic [AW-1:0] tag_i,
    input  logic [DW-1:0] fill_data_i,
    output logic          valid_o,
    output logic          ready_o,
    output logic          cnt_max_o,
    output logic [AW-1:0] tag_o,
    output logic [DW-1:0] data_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    slot_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [AW-1:0]    tag_q, tag_d;
    logic [DW-1:0]    data_q, data_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            cnt_q   <= '0;
            tag_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            tag_q   <= tag_d;
            data_q  <= data_d;
        end
    end

    // next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        tag_d   = tag_q;
        data_d  = data_q;
        unique case (state_q)
            ST_FREE: begin
                if (alloc_i) begin
                    state_d = ST_WAIT;
                    cnt_d   = CNT_ONE;
                    tag_d   = tag_i;
                end
            end
            ST_WAIT, ST_READY: begin
                if (state_q == ST_WAIT && fill_i) begin
                    state_d = ST_READY;
                    data_d  = fill_data_i;
                end
                unique case ({inc_i, dec_i})
                    2'b10: cnt_d = cnt_q + CNT_ONE;
                    2'b01: begin
                        if (cnt_q == CNT_ONE) begin
                            state_d = ST_FREE;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q - CNT_ONE;
                        end
                    end
                    default: cnt_d = cnt_q;
                endcase
            end
            default: state_d = ST_FREE;
        endcase
    end

    // outputs
    always_comb begin
        valid_o   = (state_q != ST_FREE);
        ready_o   = (state_q == ST_READY);
        cnt_max_o = (cnt_q == CNT_TOP);
        tag_o     = tag_q;
        data_o    = data_q;
    end

endmodule

// File: rtl/mrb_lookup.sv
module mrb_lookup #(
    parameter int K  = 3,
    parameter int AW = 16,
    parameter int IW = (K > 1) ? $clog2(K) : 1
) (
    input  logic [AW-1:0]   addr_i,
    input  logic [K-1:0]    valid_i,
    input  logic [K*AW-1:0] tags_i,
    output logic [K-1:0]    match_o,
    output logic            hit_o,
    output logic            full_o,
    output logic [IW-1:0]   hit_idx_o,
    output logic [IW-1:0]   free_idx_o
);

    for (genvar g = 0; g < K; g++) begin : g_cmp
        assign match_o[g] = valid_i[g] && (tags_i[g*AW +: AW] == addr_i);
    end

    always_comb begin
        hit_o     = |match_o;
        full_o    = &valid_i;
        hit_idx_o = '0;
        for (int i = K - 1; i >= 0; i--) begin
            if (match_o[i]) hit_idx_o = IW'(i);
        end
        // first-zero search: the lowest free index wins
        free_idx_o = '0;
        for (int i = K - 1; i >= 0; i--) begin
            if (!valid_i[i]) free_idx_o = IW'(i);
        end
    end

endmodule

// File: rtl/mrb_merge_buf.sv
module mrb_merge_buf #(
    parameter int K     = 3,
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int CNT_W = 2,
    parameter int IW    = (K > 1) ? $clog2(K) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          req_hit,
    output logic [IW-1:0] req_slot,
    output logic          req_stall,
    output logic          bank_req,
    input  logic          fill_valid,
    input  logic [IW-1:0] fill_slot,
    input  logic [DW-1:0] fill_data,
    input  logic          dep_valid,
    input  logic [IW-1:0] dep_slot,
    output logic [DW-1:0] dep_data
);

    logic [K-1:0]    valid_v, ready_v, cmax_v, match_v;
    logic [K*AW-1:0] tags_v;
    logic [K*DW-1:0] data_v;
    logic            hit, full;
    logic [IW-1:0]   hit_idx, free_idx;
    logic            accept;

    mrb_lookup #(.K(K), .AW(AW), .IW(IW)) lookup_i (
        .addr_i     (req_addr),
        .valid_i    (valid_v),
        .tags_i     (tags_v),
        .match_o    (match_v),
        .hit_o      (hit),
        .full_o     (full),
        .hit_idx_o  (hit_idx),
        .free_idx_o (free_idx)
    );

    always_comb begin
        req_hit   = req_valid && hit;
        req_slot  = hit ? hit_idx : free_idx;
        req_stall = req_valid && (hit ? cmax_v[hit_idx] : full);
        bank_req  = req_valid && !hit && !full;
        accept    = req_valid && !req_stall;
    end

    for (genvar g = 0; g < K; g++) begin : g_slot
        logic sel_alloc, sel_inc, sel_dec, sel_fill;
        assign sel_alloc = accept && !hit && (free_idx == IW'(g));
        assign sel_inc   = accept && match_v[g];
        assign sel_dec   = dep_valid && (dep_slot == IW'(g));
        assign sel_fill  = fill_valid && (fill_slot == IW'(g));

        mrb_slot #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) slot_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc_i     (sel_alloc),
            .inc_i       (sel_inc),
            .dec_i       (sel_dec),
            .fill_i      (sel_fill),
            .tag_i       (req_addr),
            .fill_data_i (fill_data),
            .valid_o     (valid_v[g]),
            .ready_o     (ready_v[g]),
            .cnt_max_o   (cmax_v[g]),
            .tag_o       (tags_v[g*AW +: AW]),
            .data_o      (data_v[g*DW +: DW])
        );
    end

    always_comb begin
        dep_data = '0;
        for (int i = 0; i < K; i++) begin
            if (dep_slot == IW'(i)) dep_data = data_v[i*DW +: DW];
        end
    end

endmodule

// File: rtl/mrb_merge_buf_chk.sv
module mrb_merge_buf_chk #(
    parameter int K  = 3,
    parameter int IW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_hit,
    input logic          req_stall,
    input logic          bank_req,
    input logic [IW-1:0] req_slot,
    input logic          fill_valid,
    input logic          dep_valid,
    input logic [IW-1:0] dep_slot,
    input logic [K-1:0]  valid_v,
    input logic [K-1:0]  ready_v,
    input logic [K-1:0]  match_v
);

    // R1: nothing is reported without a request
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !req_hit && !req_stall && !bank_req);

    // R2: a bank access is requested only for a miss that is taken
    a_r2_bank_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        bank_req |-> !req_hit && !req_stall);

    // R2: the claimed slot is held and waiting one cycle later
    a_r2_alloc_waits: assert property (@(posedge clk) disable iff (!rst_n)
        bank_req |=> valid_v[$past(req_slot)] && !ready_v[$past(req_slot)]);

    // R3: at most one held slot matches an address
    a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_v));

    // R6: a miss with all slots held stalls
    a_r6_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_hit && (&valid_v) |-> req_stall && !bank_req);

    // R6: a stall with no other traffic changes no slot
    a_r6_stall_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        req_stall && !dep_valid && !fill_valid |=> $stable(valid_v) && $stable(ready_v));

    // R8: delivery only from a filled slot
    a_r8_dep_ready: assert property (@(posedge clk) disable iff (!rst_n)
        dep_valid |-> ready_v[dep_slot]);

endmodule

bind mrb_merge_buf mrb_merge_buf_chk #(.K(K), .IW(IW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_hit    (req_hit),
    .req_stall  (req_stall),
    .bank_req   (bank_req),
    .req_slot   (req_slot),
    .fill_valid (fill_valid),
    .dep_valid  (dep_valid),
    .dep_slot   (dep_slot),
    .valid_v    (valid_v),
    .ready_v    (ready_v),
    .match_v    (match_v)
);

// File: tb/mrb_merge_buf_tb_top.sv
module mrb_merge_buf_tb_top;

    localparam int K  = 3;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_hit, req_stall, bank_req;
    logic [IW-1:0] req_slot;
    logic          fill_valid = 1'b0;
    logic [IW-1:0] fill_slot = '0;
    logic [DW-1:0] fill_data = '0;
    logic          dep_valid = 1'b0;
    logic [IW-1:0] dep_slot = '0;
    logic [DW-1:0] dep_data;

    always #2.5 clk = ~clk;

    mrb_merge_buf dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr),
        .req_hit(req_hit), .req_slot(req_slot),
        .req_stall(req_stall), .bank_req(bank_req),
        .fill_valid(fill_valid), .fill_slot(fill_slot), .fill_data(fill_data),
        .dep_valid(dep_valid), .dep_slot(dep_slot), .dep_data(dep_data)
    );

    typedef struct {
        logic          hit;
        logic          chk_slot;
        logic [IW-1:0] slot;
        logic          bank;
        logic          stall;
        logic          chk_dep;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    task automatic check(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // driver: one cycle of stimulus plus its expected result
    task automatic step(input logic rv, input logic [AW-1:0] ra,
                        input logic dv, input logic [IW-1:0] ds,
                        input logic fv, input logic [IW-1:0] fs, input logic [DW-1:0] fd,
                        input logic e_hit, input logic e_cs, input logic [IW-1:0] e_slot,
                        input logic e_bank, input logic e_stall,
                        input logic e_cd, input logic [DW-1:0] e_data, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = rv; req_addr = ra;
        dep_valid = dv; dep_slot = ds;
        fill_valid = fv; fill_slot = fs; fill_data = fd;
        e.hit = e_hit; e.chk_slot = e_cs; e.slot = e_slot; e.bank = e_bank;
        e.stall = e_stall; e.chk_dep = e_cd; e.data = e_data; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: sample one time unit after the falling edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                check(e.tag, "req_hit", req_hit, e.hit);
                check(e.tag, "bank_req", bank_req, e.bank);
                check(e.tag, "req_stall", req_stall, e.stall);
                if (e.chk_slot) check(e.tag, "req_slot", req_slot, e.slot);
                if (e.chk_dep) check(e.tag, "dep_data", dep_data, e.data);
            end
        end
    end

    localparam logic [AW-1:0] A = 16'h1A00, B = 16'h2B00, C = 16'h3C00, E = 16'h4E00;
    localparam logic [DW-1:0] D0 = 32'hA0A0_0001, D1 = 32'hB1B1_0002, D2 = 32'hC2C2_0003;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset
        step(0, 0, 0, 0, 0, 0, 0,  0, 0, 0, 0, 0,  0, 0, "R1");
        // R2: misses claim lowest free slots
        step(1, A, 0, 0, 0, 0, 0,  0, 1, 0, 1, 0,  0, 0, "R2");
        step(1, B, 0, 0, 0, 0, 0,  0, 1, 1, 1, 0,  0, 0, "R2");
        // R3: hit on A, A count = 2
        step(1, A, 0, 0, 0, 0, 0,  1, 1, 0, 0, 0,  0, 0, "R3");
        // R8: fills
        step(0, 0, 0, 0, 1, 0, D0, 0, 0, 0, 0, 0,  0, 0, "R8");
        step(0, 0, 0, 0, 1, 1, D1, 0, 0, 0, 0, 0,  0, 0, "R8");
        step(1, C, 0, 0, 0, 0, 0,  0, 1, 2, 1, 0,  0, 0, "R2");
        // R6: full miss stalls, and changes nothing
        step(1, E, 0, 0, 0, 0, 0,  0, 0, 0, 0, 1,  0, 0, "R6");
        step(1, E, 0, 0, 0, 0, 0,  0, 0, 0, 0, 1,  0, 0, "R6");
        step(1, C, 0, 0, 0, 0, 0,  1, 1, 2, 0, 0,  0, 0, "R6");   // C count = 2
        // R7: hit and delivery on A in one cycle, A stays at 2
        step(1, A, 1, 0, 0, 0, 0,  1, 1, 0, 0, 0,  1, D0, "R7");
        step(0, 0, 1, 0, 0, 0, 0,  0, 0, 0, 0, 0,  1, D0, "R8");  // A = 1
        // R4: still held after one fewer delivery than requests
        step(1, A, 0, 0, 0, 0, 0,  1, 1, 0, 0, 0,  0, 0, "R4");   // A = 2
        step(0, 0, 1, 0, 0, 0, 0,  0, 0, 0, 0, 0,  1, D0, "R4");  // A = 1
        step(0, 0, 1, 0, 0, 0, 0,  0, 0, 0, 0, 0,  1, D0, "R4");  // A = 0, released
        // R5: released slot 0 is claimed again
        step(1, A, 0, 0, 0, 0, 0,  0, 1, 0, 1, 0,  0, 0, "R5");
        // R9: saturate B (slot 1) to 3, then a further hit stalls
        step(1, B, 0, 0, 0, 0, 0,  1, 1, 1, 0, 0,  0, 0, "R9");
        step(1, B, 0, 0, 0, 0, 0,  1, 1, 1, 0, 0,  0, 0, "R9");
        step(1, B, 0, 0, 0, 0, 0,  1, 1, 1, 0, 1,  0, 0, "R9");
        step(0, 0, 1, 1, 0, 0, 0,  0, 0, 0, 0, 0,  1, D1, "R9");
        step(0, 0, 1, 1, 0, 0, 0,  0, 0, 0, 0, 0,  1, D1, "R9");
        step(1, B, 1, 1, 0, 0, 0,  1, 1, 1, 0, 0,  1, D1, "R9"); // B stays at 1
        step(0, 0, 1, 1, 0, 0, 0,  0, 0, 0, 0, 0,  1, D1, "R9"); // B released
        step(1, B, 0, 0, 0, 0, 0,  0, 1, 1, 1, 0,  0, 0, "R9");  // no hidden count left
        // R8: new fill on reclaimed slot 0 is what departs
        step(0, 0, 0, 0, 1, 0, D2, 0, 0, 0, 0, 0,  0, 0, "R8");
        step(0, 0, 1, 0, 0, 0, 0,  0, 0, 0, 0, 0,  1, D2, "R8");
        step(0, 0, 0, 0, 0, 0, 0,  0, 0, 0, 0, 0,  0, 0, "R1");
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule